// File: doc/BRIEF.md
# Banked Floating-Point Register File

This block holds the floating-point register state of a processor core: thirty-two physical 32-bit registers arranged as two banks of sixteen. A mode bit in the status/control word picks which bank is the front bank. Single-register accesses always land in the front bank. Accesses to a 64-bit register pair can reach either bank: the lowest bit of the 4-bit register field flips the bank choice, and the upper three bits name an aligned even/odd pair.

Two combinational read ports and one clocked write port serve the execution pipeline. Each port carries a size select, so it moves either a single register or a pair. A 32-bit transfer register, FPUL, links the integer and floating-point sides. It can be loaded from outside, copied into a single register, or loaded from a single register. The status/control word has strobes that invert the bank-select and transfer-size bits. A masked write port replaces the whole word.

Top module: `fpr_bank_file`

## Requirements
- R1: A single access to 4-bit field f reaches physical register {FR, f}, where FR is status bit 21 and physical registers 16..31 form bank 1. A single read returns the register in bits 31:0 of the read data and zero in bits 63:32.
- R2: A pulse on tog_bank inverts status bit 21 (FR). A pulse on tog_size inverts status bit 20 (SZ). Status bit 19 is the precision bit PR. Each change is visible on the cycle after the pulse and applies to every access from that cycle on. With no strobe and no status write, the status word holds its value.
- R3: A pair write to field f uses bank FR XOR f[0] and registers 2*f[3:1] (even) and 2*f[3:1]+1 (odd) of that bank. The even register takes data bits 63:32 and the odd register takes bits 31:0.
- R4: A pair read uses the same mapping as R3 and returns {even, odd}, so a pair in the back bank can be read without changing FR.
- R5: A status write stores the written word ANDed with 0x003FFFFF. The status read port always returns the stored word under that same mask.
- R6: When a status write and a toggle strobe fall in the same cycle, the written value wins and the toggle is lost.
- R7: fpul_ld_en loads FPUL from fpul_ld_data. fpul_to_reg copies FPUL unchanged into the single register that wr_idx selects. When wr_en is also high in that cycle, the copy wins and the write port is ignored.
- R8: reg_to_fpul loads FPUL from the single register that rd_a_idx selects, whatever rd_a_pair is. It takes priority over fpul_ld_en. While it is high, read port A shows that single register.
- R9: Writes commit on the rising clock edge. A read of a register that is being written in the same cycle returns the old value.
- R10: A synchronous reset clears all 32 registers and FPUL to zero and loads the status word with 0x00040001, so FR, SZ and PR all start at zero.
- R11: The two read ports are independent: each has its own index and size select and can read different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Register field, read port A |
| rd_a_pair | input | 1 | Port A reads a 64-bit pair |
| rd_a_data | output | 64 | Port A read data |
| rd_b_idx | input | 4 | Register field, read port B |
| rd_b_pair | input | 1 | Port B reads a 64-bit pair |
| rd_b_data | output | 64 | Port B read data |
| wr_en | input | 1 | Write enable |
| wr_pair | input | 1 | Write a 64-bit pair |
| wr_idx | input | 4 | Register field for the write, and target of fpul_to_reg |
| wr_data | input | 64 | Write data; single writes use bits 31:0 |
| fpul_ld_en | input | 1 | Load FPUL from fpul_ld_data |
| fpul_ld_data | input | 32 | Value for FPUL |
| fpul_to_reg | input | 1 | Copy FPUL into a single register |
| reg_to_fpul | input | 1 | Copy a single register into FPUL |
| fpul_data | output | 32 | Current FPUL value |
| tog_bank | input | 1 | Invert the bank-select bit |
| tog_size | input | 1 | Invert the transfer-size bit |
| ctl_wr_en | input | 1 | Write the status/control word |
| ctl_wr_data | input | 32 | Status/control write value |
| ctl_rd_data | output | 32 | Masked status/control word |
| mode_fr | output | 1 | Bank-select bit |
| mode_sz | output | 1 | Transfer-size bit |
| mode_pr | output | 1 | Precision bit |

## Verification
The assertions check on every cycle the register-level transitions: the mask on status writes, the toggles flipping exactly one bit, the status word holding when nothing acts on it, the pair write splitting its halves into the mapped even and odd registers, and the movements of FPUL. The index remapping itself can only be shown by the bench's scenarios. Those scenarios write through one bank setting and read back through another, reach back-bank pairs with bit 0 of the field, and cover conflicts within one cycle, read-during-write and a reset in the middle of the run.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned BANK_REGS = 16;
    localparam int unsigned IDX_W     = $clog2(BANK_REGS);
    localparam int unsigned PHYS_W    = IDX_W + 1;
    localparam int unsigned NUM_PHYS  = 2 * BANK_REGS;
    localparam int unsigned PAIR_W    = 2 * DATA_W;
    localparam int unsigned CTL_W     = 32;

    localparam logic [CTL_W-1:0] CTL_MASK  = 32'h003F_FFFF;
    localparam logic [CTL_W-1:0] CTL_RESET = 32'h0004_0001;
    localparam int unsigned BIT_FR = 21;
    localparam int unsigned BIT_SZ = 20;
    localparam int unsigned BIT_PR = 19;

    localparam int unsigned NUM_RD    = 2;
    localparam int unsigned NUM_MAP   = NUM_RD + 1;
    localparam int unsigned MAP_WR    = 0;
    localparam int unsigned MAP_RD0   = 1;

    typedef logic [IDX_W-1:0]  field_t;
    typedef logic [PHYS_W-1:0] phys_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [PAIR_W-1:0] dword_t;

    typedef struct packed {
        logic fr;
        logic sz;
        logic pr;
    } mode_t;

    // Resolved access: hi is the even (upper) register, lo the odd one.
    // For a single access both name the same register.
    typedef struct packed {
        logic  pair;
        phys_t hi;
        phys_t lo;
    } acc_t;

    function automatic acc_t map_access(input field_t f, input logic pair, input logic fr);
        acc_t  a;
        logic  bank;
        a.pair = pair;
        if (pair) begin
            bank = fr ^ f[0];
            a.hi = {bank, f[IDX_W-1:1], 1'b0};
            a.lo = {bank, f[IDX_W-1:1], 1'b1};
        end else begin
            a.hi = {fr, f};
            a.lo = {fr, f};
        end
        return a;
    endfunction

endpackage

// File: rtl/fpr_index_map.sv
module fpr_index_map
    import fpr_pkg::*;
(
    input  field_t field_i,
    input  logic   pair_i,
    input  logic   fr_i,
    output acc_t   acc_o
);

    always_comb begin
        acc_o = map_access(field_i, pair_i, fr_i);
    end

endmodule

// File: rtl/fpr_ctl.sv
module fpr_ctl
    import fpr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tog_bank,
    input  logic             tog_size,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] ctl_q,
    output mode_t            mode
);

    logic [CTL_W-1:0] ctl_next;

    always_comb begin
        ctl_next = ctl_q;
        if (wr_en) begin
            ctl_next = wr_data & CTL_MASK;
        end else begin
            if (tog_bank) ctl_next[BIT_FR] = ~ctl_q[BIT_FR];
            if (tog_size) ctl_next[BIT_SZ] = ~ctl_q[BIT_SZ];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= CTL_RESET;
        else     ctl_q <= ctl_next;
    end

    assign mode.fr = ctl_q[BIT_FR];
    assign mode.sz = ctl_q[BIT_SZ];
    assign mode.pr = ctl_q[BIT_PR];

    AST_CTL_WRITE_MASKED: assert property (@(posedge clk) disable iff (rst)
        (!rst && wr_en) |=> (ctl_q == ($past(wr_data) & CTL_MASK))); // R5
    AST_BANK_FLIP: assert property (@(posedge clk) disable iff (rst)
        (!rst && tog_bank && !wr_en) |=> (mode.fr != $past(mode.fr))); // R2
    AST_SIZE_FLIP: assert property (@(posedge clk) disable iff (rst)
        (!rst && tog_size && !wr_en) |=> (mode.sz != $past(mode.sz))); // R2
    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rst && !wr_en && !tog_bank && !tog_size) |=> $stable(ctl_q)); // R2
    AST_CTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!rst && wr_en) |=> (ctl_q[CTL_W-1:BIT_FR+1] == '0)); // R5

endmodule

// File: rtl/fpr_storage.sv
module fpr_storage
    import fpr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  acc_t   wr_acc,
    input  logic   wr_en,
    input  dword_t wr_data,
    input  logic   fpul_ld_en,
    input  word_t  fpul_ld_data,
    input  logic   fpul_to_reg,
    input  logic   reg_to_fpul,
    input  acc_t   rd_acc  [NUM_RD],
    output dword_t rd_data [NUM_RD],
    output word_t  fpul_q
);

    word_t regs [NUM_PHYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(NUM_PHYS); i++) regs[i] <= '0;
            fpul_q <= '0;
        end else begin
            if (fpul_to_reg) begin
                regs[wr_acc.hi] <= fpul_q;
            end else if (wr_en) begin
                if (wr_acc.pair) begin
                    regs[wr_acc.hi] <= wr_data[PAIR_W-1:DATA_W];
                    regs[wr_acc.lo] <= wr_data[DATA_W-1:0];
                end else begin
                    regs[wr_acc.hi] <= wr_data[DATA_W-1:0];
                end
            end
            if (reg_to_fpul)     fpul_q <= regs[rd_acc[0].hi];
            else if (fpul_ld_en) fpul_q <= fpul_ld_data;
        end
    end

    for (genvar g = 0; g < int'(NUM_RD); g++) begin : g_rd
        always_comb begin
            if (rd_acc[g].pair) rd_data[g] = {regs[rd_acc[g].hi], regs[rd_acc[g].lo]};
            else                rd_data[g] = {{DATA_W{1'b0}}, regs[rd_acc[g].hi]};
        end
    end

    AST_PAIR_SPLIT: assert property (@(posedge clk) disable iff (rst)
        (!rst && wr_en && !fpul_to_reg && wr_acc.pair) |=>
        ((regs[$past(wr_acc.hi)] == $past(wr_data[PAIR_W-1:DATA_W])) &&
         (regs[$past(wr_acc.lo)] == $past(wr_data[DATA_W-1:0])))); // R3
    AST_FPUL_INTO_REG: assert property (@(posedge clk) disable iff (rst)
        (!rst && fpul_to_reg) |=> (regs[$past(wr_acc.hi)] == $past(fpul_q))); // R7
    AST_REG_INTO_FPUL: assert property (@(posedge clk) disable iff (rst)
        (!rst && reg_to_fpul) |=> (fpul_q == $past(regs[rd_acc[0].hi]))); // R8
    AST_FPUL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!rst && fpul_ld_en && !reg_to_fpul) |=> (fpul_q == $past(fpul_ld_data))); // R7
    AST_FPUL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rst && !fpul_ld_en && !reg_to_fpul) |=> $stable(fpul_q)); // R7

endmodule

// File: rtl/fpr_bank_file.sv
module fpr_bank_file
    import fpr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    rd_a_idx,
    input  logic          rd_a_pair,
    output logic [63:0]   rd_a_data,
    input  logic [3:0]    rd_b_idx,
    input  logic          rd_b_pair,
    output logic [63:0]   rd_b_data,
    input  logic          wr_en,
    input  logic          wr_pair,
    input  logic [3:0]    wr_idx,
    input  logic [63:0]   wr_data,
    input  logic          fpul_ld_en,
    input  logic [31:0]   fpul_ld_data,
    input  logic          fpul_to_reg,
    input  logic          reg_to_fpul,
    output logic [31:0]   fpul_data,
    input  logic          tog_bank,
    input  logic          tog_size,
    input  logic          ctl_wr_en,
    input  logic [31:0]   ctl_wr_data,
    output logic [31:0]   ctl_rd_data,
    output logic          mode_fr,
    output logic          mode_sz,
    output logic          mode_pr
);

    mode_t            mode;
    logic [CTL_W-1:0] ctl_q;
    field_t           map_field [NUM_MAP];
    logic             map_pair  [NUM_MAP];
    acc_t             map_acc   [NUM_MAP];
    acc_t             rd_acc    [NUM_RD];
    dword_t           rd_data   [NUM_RD];

    // Transfers through FPUL always address a single register.
    assign map_field[MAP_WR]    = wr_idx;
    assign map_pair[MAP_WR]     = wr_pair & ~fpul_to_reg;
    assign map_field[MAP_RD0]   = rd_a_idx;
    assign map_pair[MAP_RD0]    = rd_a_pair & ~reg_to_fpul;
    assign map_field[MAP_RD0+1] = rd_b_idx;
    assign map_pair[MAP_RD0+1]  = rd_b_pair;

    for (genvar g = 0; g < int'(NUM_MAP); g++) begin : g_map
        fpr_index_map u_map (
            .field_i (map_field[g]),
            .pair_i  (map_pair[g]),
            .fr_i    (mode.fr),
            .acc_o   (map_acc[g])
        );
    end

    for (genvar g = 0; g < int'(NUM_RD); g++) begin : g_rdsel
        assign rd_acc[g] = map_acc[MAP_RD0+g];
    end

    fpr_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .tog_bank (tog_bank),
        .tog_size (tog_size),
        .wr_en    (ctl_wr_en),
        .wr_data  (ctl_wr_data),
        .ctl_q    (ctl_q),
        .mode     (mode)
    );

    fpr_storage u_store (
        .clk          (clk),
        .rst          (rst),
        .wr_acc       (map_acc[MAP_WR]),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .fpul_ld_en   (fpul_ld_en),
        .fpul_ld_data (fpul_ld_data),
        .fpul_to_reg  (fpul_to_reg),
        .reg_to_fpul  (reg_to_fpul),
        .rd_acc       (rd_acc),
        .rd_data      (rd_data),
        .fpul_q       (fpul_data)
    );

    assign rd_a_data   = rd_data[0];
    assign rd_b_data   = rd_data[1];
    assign ctl_rd_data = ctl_q & CTL_MASK;
    assign mode_fr     = mode.fr;
    assign mode_sz     = mode.sz;
    assign mode_pr     = mode.pr;

    AST_RESET_STATUS: assert property (@(posedge clk)
        rst |=> (ctl_rd_data == CTL_RESET && fpul_data == '0)); // R10

endmodule

// File: tb/fpr_bank_file_tb.sv
module fpr_bank_file_tb_top;

    localparam time CLK_HALF = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic        rd_a_pair, rd_b_pair, wr_en, wr_pair;
    logic [63:0] rd_a_data, rd_b_data, wr_data;
    logic        fpul_ld_en, fpul_to_reg, reg_to_fpul;
    logic [31:0] fpul_ld_data, fpul_data;
    logic        tog_bank, tog_size, ctl_wr_en;
    logic [31:0] ctl_wr_data, ctl_rd_data;
    logic        mode_fr, mode_sz, mode_pr;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    fpr_bank_file dut_i (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_pair(rd_a_pair), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_pair(rd_b_pair), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_pair(wr_pair), .wr_idx(wr_idx), .wr_data(wr_data),
        .fpul_ld_en(fpul_ld_en), .fpul_ld_data(fpul_ld_data),
        .fpul_to_reg(fpul_to_reg), .reg_to_fpul(reg_to_fpul), .fpul_data(fpul_data),
        .tog_bank(tog_bank), .tog_size(tog_size),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
        .mode_fr(mode_fr), .mode_sz(mode_sz), .mode_pr(mode_pr)
    );

    typedef enum logic [3:0] {
        K_WS, K_WP, K_RS, K_RP, K_TB, K_TS, K_CW, K_CR, K_FL, K_F2R, K_R2F, K_FR
    } kind_t;

    typedef struct packed {
        kind_t       kind;
        logic [3:0]  idx;
        logic [63:0] data;
        logic [63:0] expv;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 35;
    localparam vec_t VECS [NVEC] = '{
        '{K_WS,  4'd3, 64'h11111111, 64'h0, 4'd1},                  // R1
        '{K_RS,  4'd3, 64'h0, 64'h0000000011111111, 4'd1},          // R1
        '{K_TB,  4'd0, 64'h0, 64'h0, 4'd2},                         // R2
        '{K_RS,  4'd3, 64'h0, 64'h0, 4'd2},                         // R2 other bank
        '{K_WS,  4'd3, 64'h22222222, 64'h0, 4'd2},                  // R2
        '{K_TB,  4'd0, 64'h0, 64'h0, 4'd2},                         // R2
        '{K_RS,  4'd3, 64'h0, 64'h0000000011111111, 4'd2},          // R2
        '{K_WP,  4'd4, 64'hAAAA0000BBBB0001, 64'h0, 4'd3},          // R3
        '{K_RS,  4'd4, 64'h0, 64'h00000000AAAA0000, 4'd3},          // R3 even=upper
        '{K_RS,  4'd5, 64'h0, 64'h00000000BBBB0001, 4'd3},          // R3 odd=lower
        '{K_RP,  4'd2, 64'h0, 64'h0000000011111111, 4'd4},          // R4
        '{K_RP,  4'd3, 64'h0, 64'h0000000022222222, 4'd4},          // R4 back bank
        '{K_WP,  4'd7, 64'hCAFEF00DDEADBEEF, 64'h0, 4'd3},          // R3 back bank
        '{K_TB,  4'd0, 64'h0, 64'h0, 4'd2},                         // R2
        '{K_RS,  4'd6, 64'h0, 64'h00000000CAFEF00D, 4'd3},          // R3
        '{K_RS,  4'd7, 64'h0, 64'h00000000DEADBEEF, 4'd3},          // R3
        '{K_RP,  4'd7, 64'h0, 64'h0, 4'd4},                         // R4
        '{K_RP,  4'd6, 64'h0, 64'hCAFEF00DDEADBEEF, 4'd4},          // R4
        '{K_FL,  4'd0, 64'h3F800000, 64'h0, 4'd7},                  // R7
        '{K_FR,  4'd0, 64'h0, 64'h000000003F800000, 4'd7},          // R7
        '{K_F2R, 4'd9, 64'h0, 64'h0, 4'd7},                         // R7
        '{K_RS,  4'd9, 64'h0, 64'h000000003F800000, 4'd7},          // R7
        '{K_TB,  4'd0, 64'h0, 64'h0, 4'd2},                         // R2
        '{K_RS,  4'd9, 64'h0, 64'h0, 4'd7},                         // R7
        '{K_R2F, 4'd3, 64'h0, 64'h0, 4'd8},                         // R8
        '{K_FR,  4'd0, 64'h0, 64'h0000000011111111, 4'd8},          // R8
        '{K_CR,  4'd0, 64'h0, 64'h0000000000040001, 4'd10},         // R10
        '{K_CW,  4'd0, 64'hFFFFFFFF, 64'h0, 4'd5},                  // R5
        '{K_CR,  4'd0, 64'h0, 64'h00000000003FFFFF, 4'd5},          // R5
        '{K_TS,  4'd0, 64'h0, 64'h0, 4'd2},                         // R2
        '{K_CR,  4'd0, 64'h0, 64'h00000000002FFFFF, 4'd2},          // R2
        '{K_TB,  4'd0, 64'h0, 64'h0, 4'd2},                         // R2
        '{K_CR,  4'd0, 64'h0, 64'h00000000000FFFFF, 4'd2},          // R2
        '{K_CW,  4'd0, 64'h0, 64'h0, 4'd5},                         // R5
        '{K_CR,  4'd0, 64'h0, 64'h0, 4'd5}                          // R5
    };

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] expv);
        checks++;
        if (got !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, expv);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_pair = 0; fpul_ld_en = 0; fpul_to_reg = 0; reg_to_fpul = 0;
        tog_bank = 0; tog_size = 0; ctl_wr_en = 0;
    endtask

    task automatic run_vec(input vec_t v);
        string tag = $sformatf("R%0d", v.req);
        case (v.kind)
            K_WS, K_WP: begin
                wr_en = 1; wr_pair = (v.kind == K_WP); wr_idx = v.idx; wr_data = v.data;
                @(negedge clk); idle();
            end
            K_RS, K_RP: begin
                rd_a_idx = v.idx; rd_a_pair = (v.kind == K_RP);
                #1 check(tag, rd_a_data, v.expv);
            end
            K_TB: begin tog_bank = 1; @(negedge clk); idle(); end
            K_TS: begin tog_size = 1; @(negedge clk); idle(); end
            K_CW: begin
                ctl_wr_en = 1; ctl_wr_data = v.data[31:0];
                @(negedge clk); idle();
            end
            K_CR: begin #1 check(tag, {32'h0, ctl_rd_data}, v.expv); end
            K_FL: begin
                fpul_ld_en = 1; fpul_ld_data = v.data[31:0];
                @(negedge clk); idle();
            end
            K_F2R: begin fpul_to_reg = 1; wr_idx = v.idx; @(negedge clk); idle(); end
            K_R2F: begin reg_to_fpul = 1; rd_a_idx = v.idx; @(negedge clk); idle(); end
            K_FR: begin #1 check(tag, {32'h0, fpul_data}, v.expv); end
            default: ;
        endcase
    endtask

    initial begin
        idle();
        rst = 1; rd_a_idx = 0; rd_b_idx = 0; rd_a_pair = 0; rd_b_pair = 0;
        wr_idx = 0; wr_data = 0; fpul_ld_data = 0; ctl_wr_data = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R10: reset state
        rd_a_idx = 4'd3; rd_b_idx = 4'd15; rd_b_pair = 1;
        #1;
        check("R10", rd_a_data, 64'h0);
        check("R10", rd_b_data, 64'h0);
        check("R10", {32'h0, ctl_rd_data}, 64'h40001);
        check("R10", {32'h0, fpul_data}, 64'h0);
        check("R10", {61'h0, mode_fr, mode_sz, mode_pr}, 64'h0);
        rd_b_pair = 0;

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R6: status write beats a toggle in the same cycle
        ctl_wr_en = 1; ctl_wr_data = 32'h0020_0000; tog_bank = 1; tog_size = 1;
        @(negedge clk); idle();
        #1 check("R6", {32'h0, ctl_rd_data}, 64'h0020_0000);
        check("R6", {63'h0, mode_fr}, 64'h1);
        ctl_wr_en = 1; ctl_wr_data = 32'h0;
        @(negedge clk); idle();

        // R9: read during write returns the old value, new value after the edge
        wr_en = 1; wr_idx = 4'd0; wr_data = 64'h55; rd_a_idx = 4'd0; rd_a_pair = 0;
        #1 check("R9", rd_a_data, 64'h0);
        @(negedge clk); idle();
        #1 check("R9", rd_a_data, 64'h55);

        // R7: FPUL copy (FPUL = 0x11111111) wins over the write port
        wr_en = 1; wr_idx = 4'd1; wr_data = 64'h77; fpul_to_reg = 1;
        @(negedge clk); idle();
        rd_a_idx = 4'd1;
        #1 check("R7", rd_a_data, 64'h11111111);

        // R8: register-to-FPUL wins over a load, ignoring rd_a_pair
        rd_a_idx = 4'd0; rd_a_pair = 1; reg_to_fpul = 1; fpul_ld_en = 1; fpul_ld_data = 32'h99;
        #1 check("R8", rd_a_data, 64'h55);
        @(negedge clk); idle(); rd_a_pair = 0;
        #1 check("R8", {32'h0, fpul_data}, 64'h55);

        // R11: both read ports at once, different sizes
        rd_a_idx = 4'd3; rd_a_pair = 0; rd_b_idx = 4'd4; rd_b_pair = 1;
        #1 check("R11", rd_a_data, 64'h11111111);
        check("R11", rd_b_data, 64'hAAAA0000BBBB0001);

        // R10: reset in the middle of the run
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        #1 check("R10", rd_a_data, 64'h0);
        check("R10", rd_b_data, 64'h0);
        check("R10", {32'h0, fpul_data}, 64'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(2 * CLK_HALF * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule